// File: doc/BRIEF.md
# PRBS7 Link Self-Test Pair

This block holds both ends of an at-speed link test. On the transmit side, a pattern source sits in the video payload stream. While its enable is low it passes the video words through unchanged. While its enable is high it replaces them with 24-bit words cut from a PRBS7 sequence. On the receive side, a verifier locks onto the incoming pattern and compares every later payload word against a local copy of the sequence. Both ends run on the pixel clock.

The verifier shows its result on one status pin. While a test runs, the pin stays high and drops for the low half of the clock period that follows each payload word containing one or more bit errors. External logic can count these drops to estimate an error rate. When the verifier enable goes low, checking stops and the pin holds the final result: high if no error was seen since the test started, low otherwise. The result is kept until a new test starts or the block is reset. A test lasts exactly as long as the verifier enable stays high.

The payload streams use valid/ready. Upstream, a word moves when `vid_valid` and `vid_ready` are both high. Downstream, a word moves when `tx_valid` and `tx_ready` are both high. When the downstream side holds `tx_ready` low, the offered word is held steady and the pattern does not advance. During a test the video input is stalled: `vid_ready` stays low. The receive input has no ready signal. The verifier takes one word on every cycle in which `rx_valid` is high.

Top module: `prbs_link_selftest`

## Requirements
- R1: While `gen_en` is high, `tx_valid` is 1 and `tx_data` carries successive PRBS7 words. The generator polynomial is x^7+x^6+1: each step produces the bit s[6]^s[5] and shifts it into s[0]. A word is 24 such steps, with the first bit in bit 23. While `gen_en` is low the state is reloaded with parameter `SEED` (default 7'h7F), so the first word of every test starts from `SEED`.
- R2: While `gen_en` is low, `tx_valid`=`vid_valid`, `tx_data`=`vid_data` and `vid_ready`=`tx_ready`. While `gen_en` is high, `vid_ready` is 0.
- R3: During a test the pattern advances one word only on a cycle with `tx_ready` high. While `tx_ready` is low the same word stays on `tx_data`.
- R4: When a test starts, the first valid received word is not compared. Its bits [6:0] seed the local sequence. This word may arrive in the same cycle that `chk_en` is first seen high, or in any later cycle.
- R5: Each later valid word is compared with the next expected word. If anywhere from 1 to 24 bits differ, `test_pass` goes low for the low half of the clock period after the edge that captured that word, and is high in the high half. The local sequence then advances from the expected word, not from the received one.
- R6: While a test runs, `test_pass` is high at all times except for the R5 pulses.
- R7: While `chk_en` is low, received words are ignored. `test_pass` holds 1 if no word mismatched since the last test start, and 0 otherwise.
- R8: Reset sets `test_pass` to 1. A new test start (`chk_en` seen high while idle) clears a held failure.
- R9: A cycle with `rx_valid` low is neither compared nor counted as a step of the sequence, and it produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_en | input | 1 | Pattern source enable |
| vid_valid | input | 1 | Video word valid |
| vid_ready | output | 1 | Video word accepted |
| vid_data | input | 24 | Video payload word |
| tx_valid | output | 1 | Outgoing payload valid |
| tx_ready | input | 1 | Downstream accepts payload |
| tx_data | output | 24 | Outgoing payload word |
| chk_en | input | 1 | Verifier enable; test length |
| rx_valid | input | 1 | Received payload valid |
| rx_data | input | 24 | Received payload word |
| test_pass | output | 1 | Error pulses during a test, held result after it |

## Verification
The verifier is fed clean sequences from a random seed word. Clean runs show that seeding and stepping line up with no false pulses. Words with a single flipped bit and with all 24 bits flipped check that both extremes of the error range raise a pulse, and the clean word that follows shows that the sequence resynchronises. Gaps in `rx_valid` and random words sent while idle separate ignored cycles from compared ones, and back-to-back tests check that a new start clears a held failure. On the transmit side, random `tx_ready` stalls mixed with enable toggling check that the pattern holds under back-pressure and restarts from the seed.

// File: rtl/prbs_st_pkg.sv
package prbs_st_pkg;
  localparam int PRBS_W = 7;
  localparam int TAP_HI = 6;
  localparam int TAP_LO = 5;

  typedef enum logic [1:0] {
    CK_IDLE = 2'd0,
    CK_SEED = 2'd1,
    CK_RUN  = 2'd2
  } ck_state_e;
endpackage

// File: rtl/prbs_stepper.sv
module prbs_stepper
  import prbs_st_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic [PRBS_W-1:0] state_i,
  output logic [WORD_W-1:0] word_o,
  output logic [PRBS_W-1:0] next_o
);
  logic [PRBS_W-1:0] chain [0:WORD_W];

  assign chain[0] = state_i;

  for (genvar i = 0; i < WORD_W; i++) begin : g_step
    logic fb;
    assign fb              = chain[i][TAP_HI] ^ chain[i][TAP_LO];
    assign chain[i+1]      = {chain[i][PRBS_W-2:0], fb};
    assign word_o[WORD_W-1-i] = fb;
  end

  assign next_o = chain[WORD_W];
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_st_pkg::*;
#(
  parameter int                WORD_W = 24,
  parameter logic [PRBS_W-1:0] SEED   = 7'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_en,
  input  logic              vid_valid,
  output logic              vid_ready,
  input  logic [WORD_W-1:0] vid_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data
);
  logic [PRBS_W-1:0] lfsr_q;
  logic [PRBS_W-1:0] lfsr_nx;
  logic [WORD_W-1:0] pat_word;

  prbs_stepper #(.WORD_W(WORD_W)) u_step (
    .state_i (lfsr_q),
    .word_o  (pat_word),
    .next_o  (lfsr_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
    end else if (!gen_en) begin
      lfsr_q <= SEED;
    end else if (tx_ready) begin
      lfsr_q <= lfsr_nx;
    end
  end

  always_comb begin
    if (gen_en) begin
      tx_valid  = 1'b1;
      tx_data   = pat_word;
      vid_ready = 1'b0;
    end else begin
      tx_valid  = vid_valid;
      tx_data   = vid_data;
      vid_ready = tx_ready;
    end
  end
endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
  import prbs_st_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_data,
  output logic              busy_o,
  output logic              err_o,
  output logic              verdict_o
);
  ck_state_e         st_q;
  logic [PRBS_W-1:0] lfsr_q;
  logic [PRBS_W-1:0] exp_nx;
  logic [WORD_W-1:0] exp_word;
  logic              mismatch;
  logic              err_q;
  logic              verdict_q;

  prbs_stepper #(.WORD_W(WORD_W)) u_step (
    .state_i (lfsr_q),
    .word_o  (exp_word),
    .next_o  (exp_nx)
  );

  assign mismatch = (rx_data != exp_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= CK_IDLE;
      lfsr_q    <= '0;
      err_q     <= 1'b0;
      verdict_q <= 1'b1;
    end else begin
      err_q <= 1'b0;
      case (st_q)
        CK_IDLE: begin
          if (chk_en) begin
            verdict_q <= 1'b1;
            if (rx_valid) begin
              lfsr_q <= rx_data[PRBS_W-1:0];
              st_q   <= CK_RUN;
            end else begin
              st_q   <= CK_SEED;
            end
          end
        end
        CK_SEED: begin
          if (!chk_en) begin
            st_q <= CK_IDLE;
          end else if (rx_valid) begin
            lfsr_q <= rx_data[PRBS_W-1:0];
            st_q   <= CK_RUN;
          end
        end
        CK_RUN: begin
          if (!chk_en) begin
            st_q <= CK_IDLE;
          end else if (rx_valid) begin
            err_q  <= mismatch;
            lfsr_q <= exp_nx;
            if (mismatch) verdict_q <= 1'b0;
          end
        end
        default: st_q <= CK_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != CK_IDLE);
  assign err_o     = err_q;
  assign verdict_o = verdict_q;
endmodule

// File: rtl/prbs_pass_drive.sv
module prbs_pass_drive (
  input  logic clk,
  input  logic busy,
  input  logic err,
  input  logic verdict,
  output logic pass_o
);
  always_comb begin
    if (busy) pass_o = ~(err & ~clk);
    else      pass_o = verdict;
  end
endmodule

// File: rtl/prbs_link_selftest.sv
module prbs_link_selftest
  import prbs_st_pkg::*;
#(
  parameter int                WORD_W = 24,
  parameter logic [PRBS_W-1:0] SEED   = 7'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_en,
  input  logic              vid_valid,
  output logic              vid_ready,
  input  logic [WORD_W-1:0] vid_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  input  logic              chk_en,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_data,
  output logic              test_pass
);
  logic chk_busy;
  logic err_pulse;
  logic verdict;

  prbs_gen #(.WORD_W(WORD_W), .SEED(SEED)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_en    (gen_en),
    .vid_valid (vid_valid),
    .vid_ready (vid_ready),
    .vid_data  (vid_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data)
  );

  prbs_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_en    (chk_en),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .busy_o    (chk_busy),
    .err_o     (err_pulse),
    .verdict_o (verdict)
  );

  prbs_pass_drive u_pass (
    .clk     (clk),
    .busy    (chk_busy),
    .err     (err_pulse),
    .verdict (verdict),
    .pass_o  (test_pass)
  );
endmodule

// File: rtl/prbs_link_selftest_sva.sv
module prbs_link_selftest_sva #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gen_en,
  input logic              vid_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [WORD_W-1:0] tx_data,
  input logic              chk_en,
  input logic              rx_valid,
  input logic              chk_busy,
  input logic              err_pulse,
  input logic              verdict
);
  p_gen_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gen_en |-> tx_valid);

  p_video_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gen_en |-> !vid_ready);

  p_hold_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && $past(gen_en) && $past(tx_valid && !tx_ready)) |-> $stable(tx_data));

  p_err_marks_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !verdict);

  p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && chk_busy && !verdict) |=> !verdict);

  p_verdict_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_en && $past(!chk_en)) |-> $stable(verdict));

  p_no_pulse_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> !err_pulse);

  p_no_pulse_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !err_pulse);
endmodule

bind prbs_link_selftest prbs_link_selftest_sva #(.WORD_W(WORD_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .gen_en    (gen_en),
  .vid_ready (vid_ready),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .chk_en    (chk_en),
  .rx_valid  (rx_valid),
  .chk_busy  (chk_busy),
  .err_pulse (err_pulse),
  .verdict   (verdict)
);

// File: tb/tb_prbs_link_selftest.sv
module tb_prbs_link_selftest;
  localparam int CLK_P = 10;
  localparam logic [6:0] SEED = 7'h7F;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        gen_en, vid_valid, vid_ready, tx_valid, tx_ready;
  logic [23:0] vid_data, tx_data;
  logic        chk_en, rx_valid, test_pass;
  logic [23:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench models
  logic [6:0] g_st;
  bit         m_run, m_seeded, m_verdict, m_pulse;
  logic [6:0] m_lfsr;

  always #(CLK_P/2) clk = ~clk;

  prbs_link_selftest dut (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en),
    .vid_valid(vid_valid), .vid_ready(vid_ready), .vid_data(vid_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .chk_en(chk_en), .rx_valid(rx_valid), .rx_data(rx_data),
    .test_pass(test_pass)
  );

  function automatic logic [30:0] step_word(input logic [6:0] s);
    logic [23:0] w;
    logic        b;
    w = '0;
    for (int i = 0; i < 24; i++) begin
      b = s[6] ^ s[5];
      w = {w[22:0], b};
      s = {s[5:0], b};
    end
    return {s, w};
  endfunction

  function automatic logic [23:0] next_exp();
    logic [30:0] r;
    r = step_word(m_lfsr);
    return r[23:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h @%0t", req, what, act, exp, $time);
    end
  endtask

  // One cycle: inputs are driven in the low phase, then edge, then checks.
  task automatic cycle(input logic ge, input logic tr, input logic vv, input logic [23:0] vd,
                       input logic ce, input logic rv, input logic [23:0] rd);
    logic [30:0] r;
    string       ctag;
    bit          exp_hi, exp_lo;
    gen_en = ge; tx_ready = tr; vid_valid = vv; vid_data = vd;
    chk_en = ce; rx_valid = rv; rx_data = rd;
    // generator model, updated at the coming edge
    if (!ge) g_st = SEED;
    else if (tr) begin r = step_word(g_st); g_st = r[30:24]; end
    // checker model
    m_pulse = 0;
    ctag = "R6";
    if (!m_run) begin
      if (ce) begin
        m_verdict = 1; m_run = 1; ctag = "R8";
        if (rv) begin m_lfsr = rd[6:0]; m_seeded = 1; ctag = "R4"; end
        else m_seeded = 0;
      end else ctag = "R7";
    end else if (!ce) begin
      m_run = 0; ctag = "R7";
    end else if (!m_seeded) begin
      if (rv) begin m_lfsr = rd[6:0]; m_seeded = 1; ctag = "R4"; end
      else ctag = "R9";
    end else if (rv) begin
      r = step_word(m_lfsr);
      m_pulse = (rd != r[23:0]);
      if (m_pulse) begin m_verdict = 0; ctag = "R5"; end
      m_lfsr = r[30:24];
    end else ctag = "R9";
    exp_hi = m_run ? 1'b1 : m_verdict;
    exp_lo = m_run ? !m_pulse : m_verdict;

    @(posedge clk); #2;
    if (ge) begin
      r = step_word(g_st);
      check(tx_valid == 1'b1, "R1", "tx_valid", 32'(tx_valid), 32'd1);
      check(tx_data == r[23:0], tr ? "R1" : "R3", "tx_data", 32'(tx_data), 32'(r[23:0]));
      check(vid_ready == 1'b0, "R2", "vid_ready stall", 32'(vid_ready), 32'd0);
    end else begin
      check(tx_valid == vv && tx_data == vd && vid_ready == tr, "R2", "pass-through",
            {7'd0, tx_valid, tx_data}, {7'd0, vv, vd});
    end
    check(test_pass == exp_hi, ctag, "test_pass high phase", 32'(test_pass), 32'(exp_hi));
    #5;
    check(test_pass == exp_lo, ctag, "test_pass low phase", 32'(test_pass), 32'(exp_lo));
  endtask

  task automatic rx_cycle(input logic ce, input logic rv, input logic [23:0] rd);
    cycle(1'b0, 1'b1, 1'b0, 24'h0, ce, rv, rd);
  endtask

  initial begin
    logic [31:0] rnd;
    logic [23:0] w;
    void'($urandom(32'd20240607));
    rst_n = 0; gen_en = 0; tx_ready = 0; vid_valid = 0; vid_data = '0;
    chk_en = 0; rx_valid = 0; rx_data = '0;
    g_st = SEED; m_run = 0; m_seeded = 0; m_verdict = 1; m_lfsr = '0; m_pulse = 0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
    check(test_pass == 1'b1, "R8", "reset test_pass", 32'(test_pass), 32'd1);
    #5;
    check(test_pass == 1'b1, "R8", "reset test_pass low phase", 32'(test_pass), 32'd1);

    // R2 pass-through, directed words
    cycle(1'b0, 1'b1, 1'b1, 24'hA5A5A5, 1'b0, 1'b0, 24'h0);
    cycle(1'b0, 1'b0, 1'b1, 24'h123456, 1'b0, 1'b0, 24'h0);
    // R1/R3 generator from seed, with a stall in the middle
    cycle(1'b1, 1'b1, 1'b1, 24'hFFFFFF, 1'b0, 1'b0, 24'h0);
    cycle(1'b1, 1'b0, 1'b1, 24'hFFFFFF, 1'b0, 1'b0, 24'h0);
    cycle(1'b1, 1'b0, 1'b0, 24'h0, 1'b0, 1'b0, 24'h0);
    cycle(1'b1, 1'b1, 1'b0, 24'h0, 1'b0, 1'b0, 24'h0);
    cycle(1'b0, 1'b1, 1'b0, 24'h0, 1'b0, 1'b0, 24'h0);
    cycle(1'b1, 1'b1, 1'b0, 24'h0, 1'b0, 1'b0, 24'h0);

    // R4: seed in the enable cycle; R6 clean run
    rnd = $urandom();
    rx_cycle(1'b1, 1'b1, rnd[23:0]);
    for (int i = 0; i < 6; i++) rx_cycle(1'b1, 1'b1, next_exp());
    // R5 single bit error, then resync
    w = next_exp(); rx_cycle(1'b1, 1'b1, w ^ 24'h000001);
    rx_cycle(1'b1, 1'b1, next_exp());
    // R9 gap
    rx_cycle(1'b1, 1'b0, 24'hFFFFFF);
    rx_cycle(1'b1, 1'b1, next_exp());
    // R5 all 24 bits wrong
    w = next_exp(); rx_cycle(1'b1, 1'b1, ~w);
    rx_cycle(1'b1, 1'b1, next_exp());
    // R7 held fail, ignored words
    rx_cycle(1'b0, 1'b1, 24'h0);
    for (int i = 0; i < 4; i++) begin rnd = $urandom(); rx_cycle(1'b0, 1'b1, rnd[23:0]); end
    // R8 new test clears; seed arrives one cycle later
    rx_cycle(1'b1, 1'b0, 24'h0);
    rnd = $urandom();
    rx_cycle(1'b1, 1'b1, rnd[23:0]);
    for (int i = 0; i < 5; i++) rx_cycle(1'b1, 1'b1, next_exp());
    // R7 held pass
    rx_cycle(1'b0, 1'b0, 24'h0);
    rx_cycle(1'b0, 1'b1, 24'h555555);
    rx_cycle(1'b0, 1'b0, 24'h0);

    // random mix on both sides
    for (int i = 0; i < 600; i++) begin
      logic ge, tr, vv, ce, rv;
      logic [23:0] vd, rd;
      rnd = $urandom(); ge = (rnd[3:0] != 0) ? gen_en : ~gen_en;
      tr = rnd[4] | rnd[5]; vv = rnd[6];
      rnd = $urandom(); vd = rnd[23:0];
      rnd = $urandom(); ce = (rnd[5:0] != 0) ? chk_en : ~chk_en;
      rv = (rnd[9:8] != 0);
      if (m_run && m_seeded) begin
        rd = next_exp();
        if (rnd[15:12] == 0) begin
          logic [31:0] f;
          f = $urandom();
          rd = rd ^ (f[23:0] == 0 ? 24'h800000 : f[23:0]);
        end
      end else begin
        logic [31:0] f;
        f = $urandom(); rd = f[23:0];
      end
      cycle(ge, tr, vv, vd, ce, rv, rd);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule